// File: doc/BRIEF.md
# Bidirectional Parallel Port Register Interface

This block is the register front end of a byte-wide parallel printer port. A host reaches it through a small synchronous bus with a 2-bit address, a write strobe and a read-data output. Reads are combinational and have no side effects. Writes take effect at the next rising clock edge. Every access completes without wait states.

The block has four address slots:
- The data slot drives or samples eight data pins.
- The status slot returns the synchronised printer status lines when read. When written, it loads a direction-select byte.
- The control slot stores six bits. Four of them drive the printer control lines and one gives the interrupt enable to a separate interrupt block.
- The spare slot reads as zero and ignores writes.

The data pins change direction under one of two schemes, chosen by a strap input. With the strap high, control bit 5 picks the direction. With the strap low, the data pins drive only while the direction-select byte holds a fixed key value.

Top module: `lpt_port_regs`

## Requirements
- R1: After reset the data slot (address 0) reads 0x00 while the pins drive, the status slot (address 1) reads 0x07 with all status inputs low, and the control slot (address 2) reads 0xE0. At that point strobe_o, autofd_o and selin_o are 1, and init_o and irq_en_o are 0.
- R2: A write to address 2 stores bits 5:0. A read of address 2 returns the stored bits 4:0 with bits 7:5 forced to 1, so a write of 0x1F reads 0xFF and a write of 0xD0 reads 0xF0.
- R3: strobe_o, autofd_o and selin_o are the inverse of control bits 0, 1 and 3. init_o equals control bit 2 without inversion. irq_en_o equals control bit 4.
- R4: Reading address 1 returns err_i, slct_i, pe_i, ack_i and busy_i in bits 3, 4, 5, 6 and 7, not inverted, with bits 2:0 always 1. A change on a status input first shows on the second rising edge after it is applied.
- R5: With bidir_en_i high, the data pins are in input mode exactly when control bit 5 is 1. The direction-select byte is then ignored.
- R6: With bidir_en_i low, the data pins are in output mode only while the direction-select byte equals 0x55. Any other value, including 0xAA and the reset value 0x00, gives input mode, whatever control bit 5 holds.
- R7: A write to address 1 loads the direction-select byte. A read of address 1 returns status, never the select byte.
- R8: In output mode, pd_oe is 1, pd_out bit n carries bit n of the last byte written to address 0, and a read of address 0 returns that byte.
- R9: In input mode, pd_oe is 0 and pd_out is 0x00. A read of address 0 returns the live pd_in value. A write to address 0 is discarded, so the previously stored byte reappears once output mode returns.
- R10: Address 3 reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register slot address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| bidir_en_i | input | 1 | Strap: 1 = control bit 5 selects direction, 0 = select byte does |
| pd_in | input | 8 | Sampled value of the data pins |
| pd_out | output | 8 | Value driven on the data pins |
| pd_oe | output | 1 | Data pin output enable |
| err_i | input | 1 | Printer error status line |
| slct_i | input | 1 | Printer selected status line |
| pe_i | input | 1 | Paper-empty status line |
| ack_i | input | 1 | Acknowledge status line |
| busy_i | input | 1 | Busy status line |
| strobe_o | output | 1 | Strobe control line (inverted control bit 0) |
| autofd_o | output | 1 | Auto-feed control line (inverted control bit 1) |
| init_o | output | 1 | Initialise control line (control bit 2) |
| selin_o | output | 1 | Select-in control line (inverted control bit 3) |
| irq_en_o | output | 1 | Interrupt enable for the companion interrupt block |

## Verification
The discarded data write is the hardest case to expose at the ports. While the pins are in input mode, address 0 reads pd_in and never the stored byte, so a lost or accepted write cannot be seen there. To reach it, the stimulus first stores a known byte in output mode, switches to input mode, and writes a different byte. It then returns to output mode through the same path and reads the stored byte back. The direction logic is reached through both strap settings. For each setting the stimulus sweeps control bit 5 against the key, its complement, a value one below the key, and zero.

// File: rtl/lpt_pkg.sv
`timescale 1ns/1ps
package lpt_pkg;

   // Register slot decode; the order is the bus address map
   typedef enum logic [1:0] {
      ADR_DATA  = 2'd0,
      ADR_STAT  = 2'd1,
      ADR_CTRL  = 2'd2,
      ADR_SPARE = 2'd3
   } lpt_addr_e;

   // Control bit positions
   localparam int CB_STROBE = 0;
   localparam int CB_AUTOFD = 1;
   localparam int CB_INIT   = 2;
   localparam int CB_SELIN  = 3;
   localparam int CB_IRQEN  = 4;
   localparam int CB_DIR    = 5;

   localparam int CTL_BITS  = 6;
   localparam int PIN_CTLS  = 4;
   localparam int STAT_BITS = 5;

endpackage

// File: rtl/lpt_status_sync.sv
`timescale 1ns/1ps
module lpt_status_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lpt_status_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lpt_status_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];

   AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> chain_q[0] == $past(din)); // R4

endmodule

// File: rtl/lpt_dir_sel.sv
`timescale 1ns/1ps
module lpt_dir_sel #(
   parameter int          BYTE_W = 8,
   parameter logic [7:0]  KEY    = 8'h55
) (
   input  logic              bidir_en,
   input  logic              dir_bit,
   input  logic [BYTE_W-1:0] iosel,
   output logic              in_mode
);

   localparam logic [BYTE_W-1:0] KEY_W = BYTE_W'(KEY);

   logic key_match;

   assign key_match = (iosel == KEY_W);

   // Strap picks the direction source
   always_comb begin
      if (bidir_en) begin
         in_mode = dir_bit;
      end else begin
         in_mode = !key_match;
      end
   end

endmodule

// File: rtl/lpt_regfile.sv
`timescale 1ns/1ps
module lpt_regfile
   import lpt_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CTL_W  = CTL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              in_mode,
   output logic [BYTE_W-1:0] data_q,
   output logic [CTL_W-1:0]  ctl_q,
   output logic [BYTE_W-1:0] iosel_q
);

   if (CTL_W > BYTE_W) begin : g_bad_ctl
      $error("lpt_regfile: CTL_W exceeds BYTE_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         ctl_q   <= '0;
         iosel_q <= '0;
      end else if (we) begin
         case (lpt_addr_e'(addr))
            ADR_DATA: begin
               if (!in_mode) data_q <= wdata;
            end
            ADR_STAT:  iosel_q <= wdata;
            ADR_CTRL:  ctl_q   <= wdata[CTL_W-1:0];
            default: ;
         endcase
      end
   end

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 2'(ADR_DATA) && in_mode) |=> $stable(data_q)); // R9

   AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 2'(ADR_DATA) && !in_mode) |=> data_q == $past(wdata)); // R8

   AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 2'(ADR_CTRL)) |=> ctl_q == $past(wdata[CTL_W-1:0])); // R2

   AST_IOSEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 2'(ADR_STAT)) |=> iosel_q == $past(wdata)); // R7

   AST_SPARE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 2'(ADR_SPARE)) |=>
         ($stable(data_q) && $stable(ctl_q) && $stable(iosel_q))); // R10

endmodule

// File: rtl/lpt_port_regs.sv
`timescale 1ns/1ps
module lpt_port_regs
   import lpt_pkg::*;
#(
   parameter int         BYTE_W       = 8,
   parameter int         SYNC_STAGES  = 2,
   parameter logic [7:0] DIR_KEY      = 8'h55,
   parameter logic [3:0] CTL_INV_MASK = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              bidir_en_i,
   input  logic [BYTE_W-1:0] pd_in,
   output logic [BYTE_W-1:0] pd_out,
   output logic              pd_oe,
   input  logic              err_i,
   input  logic              slct_i,
   input  logic              pe_i,
   input  logic              ack_i,
   input  logic              busy_i,
   output logic              strobe_o,
   output logic              autofd_o,
   output logic              init_o,
   output logic              selin_o,
   output logic              irq_en_o
);

   localparam int LOW_FILL_W = BYTE_W - STAT_BITS;
   localparam int CTL_RD_W   = CB_DIR;
   localparam int CTL_FILL_W = BYTE_W - CTL_RD_W;

   if (BYTE_W != 8) begin : g_bad_byte
      $error("lpt_port_regs: register layout needs BYTE_W of 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lpt_port_regs: SYNC_STAGES must be at least 2");
   end

   logic [BYTE_W-1:0]    data_q;
   logic [CTL_BITS-1:0]  ctl_q;
   logic [BYTE_W-1:0]    iosel_q;
   logic                 in_mode;
   logic [STAT_BITS-1:0] stat_raw;
   logic [STAT_BITS-1:0] stat_sync;
   logic [BYTE_W-1:0]    stat_word;
   logic [PIN_CTLS-1:0]  ctl_pins;

   lpt_regfile #(
      .BYTE_W (BYTE_W),
      .CTL_W  (CTL_BITS)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bus_we),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .in_mode (in_mode),
      .data_q  (data_q),
      .ctl_q   (ctl_q),
      .iosel_q (iosel_q)
   );

   lpt_dir_sel #(
      .BYTE_W (BYTE_W),
      .KEY    (DIR_KEY)
   ) u_dir (
      .bidir_en (bidir_en_i),
      .dir_bit  (ctl_q[CB_DIR]),
      .iosel    (iosel_q),
      .in_mode  (in_mode)
   );

   assign stat_raw = {busy_i, ack_i, pe_i, slct_i, err_i};

   lpt_status_sync #(
      .WIDTH  (STAT_BITS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (stat_raw),
      .dout  (stat_sync)
   );

   assign stat_word = {stat_sync, {LOW_FILL_W{1'b1}}};

   // Control line polarity chosen per line by mask
   for (genvar gi = 0; gi < PIN_CTLS; gi++) begin : g_ctl_pin
      if (CTL_INV_MASK[gi]) begin : g_inv
         assign ctl_pins[gi] = ~ctl_q[gi];
      end else begin : g_true
         assign ctl_pins[gi] = ctl_q[gi];
      end
   end

   assign strobe_o = ctl_pins[CB_STROBE];
   assign autofd_o = ctl_pins[CB_AUTOFD];
   assign init_o   = ctl_pins[CB_INIT];
   assign selin_o  = ctl_pins[CB_SELIN];
   assign irq_en_o = ctl_q[CB_IRQEN];

   assign pd_oe  = !in_mode;
   assign pd_out = in_mode ? '0 : data_q;

   always_comb begin
      case (lpt_addr_e'(bus_addr))
         ADR_DATA: bus_rdata = in_mode ? pd_in : data_q;
         ADR_STAT: bus_rdata = stat_word;
         ADR_CTRL: bus_rdata = {{CTL_FILL_W{1'b1}}, ctl_q[CTL_RD_W-1:0]};
         default:  bus_rdata = '0;
      endcase
   end

   AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_oe |-> pd_out == '0); // R9

   AST_STAT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'(ADR_STAT)) |-> bus_rdata[LOW_FILL_W-1:0] == {LOW_FILL_W{1'b1}}); // R4

   AST_CTL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'(ADR_CTRL)) |-> bus_rdata[BYTE_W-1:CTL_RD_W] == {CTL_FILL_W{1'b1}}); // R2

   AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'(ADR_SPARE)) |-> bus_rdata == '0); // R10

   AST_STRAP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      bidir_en_i |-> pd_oe == !ctl_q[CB_DIR]); // R5

endmodule

// File: tb/lpt_port_regs_tb.sv
`timescale 1ns/1ps
module lpt_port_regs_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_we;
   logic [1:0] bus_addr;
   logic [7:0] bus_wdata;
   logic [7:0] bus_rdata;
   logic       bidir_en_i;
   logic [7:0] pd_in;
   logic [7:0] pd_out;
   logic       pd_oe;
   logic       err_i, slct_i, pe_i, ack_i, busy_i;
   logic       strobe_o, autofd_o, init_o, selin_o, irq_en_o;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lpt_port_regs u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bidir_en_i (bidir_en_i),
      .pd_in      (pd_in),
      .pd_out     (pd_out),
      .pd_oe      (pd_oe),
      .err_i      (err_i),
      .slct_i     (slct_i),
      .pe_i       (pe_i),
      .ack_i      (ack_i),
      .busy_i     (busy_i),
      .strobe_o   (strobe_o),
      .autofd_o   (autofd_o),
      .init_o     (init_o),
      .selin_o    (selin_o),
      .irq_en_o   (irq_en_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_stat(input logic [4:0] v);
      {busy_i, ack_i, pe_i, slct_i, err_i} = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
      bidir_en_i = 1'b1; pd_in = 8'h00;
      set_stat(5'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(2'd0, r); chk("R1 data", r, 8'h00);
      rd(2'd1, r); chk("R1 status", r, 8'h07);
      rd(2'd2, r); chk("R1 control", r, 8'hE0);
      chk("R1 pins", {strobe_o, autofd_o, init_o, selin_o, irq_en_o}, 5'b11010);
      chk("R1 pd", {pd_oe, pd_out}, {1'b1, 8'h00});

      // R2 R3: every control byte
      bidir_en_i = 1'b0;
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         b = 8'(v);
         wr(2'd2, b);
         rd(2'd2, r);
         chk("R2 ctl readback", r, {3'b111, b[4:0]});
         chk("R3 ctl lines", {strobe_o, autofd_o, init_o, selin_o, irq_en_o},
             {~b[0], ~b[1], b[2], ~b[3], b[4]});
      end

      // R8: output mode sweep via strap and bit 5 = 0
      bidir_en_i = 1'b1;
      wr(2'd2, 8'h00);
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         b = 8'(255 - v);
         pd_in = ~b;
         wr(2'd0, b);
         rd(2'd0, r);
         chk("R8 data readback", r, b);
         chk("R8 pins", {pd_oe, pd_out}, {1'b1, b});
      end

      // R4: status mapping and two-edge latency
      for (int v = 0; v < 32; v++) begin
         logic [4:0] s;
         s = 5'(v);
         @(negedge clk);
         set_stat(s);
         @(negedge clk);
         rd(2'd1, r);
         chk("R4 status before second edge", r, {5'(v == 0 ? 0 : v - 1), 3'b111});
         @(negedge clk);
         rd(2'd1, r);
         chk("R4 status mapped", r, {s, 3'b111});
      end
      @(negedge clk);
      set_stat(5'b00001);
      repeat (3) @(negedge clk);
      rd(2'd1, r); chk("R4 error in bit 3", r, 8'h0F);
      set_stat(5'b10000);
      repeat (3) @(negedge clk);
      rd(2'd1, r); chk("R4 busy in bit 7", r, 8'h87);
      set_stat(5'b0);
      repeat (3) @(negedge clk);

      // R5 R9: strap high, control bit 5 picks input
      wr(2'd0, 8'h3C);
      wr(2'd1, 8'h55);
      wr(2'd2, 8'h20);
      chk("R5 bit5 gives input", pd_oe, 1'b0);
      chk("R9 pd quiet", pd_out, 8'h00);
      pd_in = 8'hA5;
      rd(2'd0, r); chk("R9 live pins", r, 8'hA5);
      pd_in = 8'h5A;
      rd(2'd0, r); chk("R9 live pins follow", r, 8'h5A);
      wr(2'd0, 8'hFF);
      rd(2'd0, r); chk("R9 write not read back", r, 8'h5A);
      wr(2'd1, 8'hAA);
      chk("R5 select byte ignored", pd_oe, 1'b0);
      wr(2'd2, 8'h00);
      chk("R5 bit5 clear gives output", pd_oe, 1'b1);
      rd(2'd0, r); chk("R9 discarded write", r, 8'h3C);
      chk("R9 old byte on pins", pd_out, 8'h3C);

      // R6 R7: strap low, key selects output
      bidir_en_i = 1'b0;
      for (int c = 0; c < 2; c++) begin
         wr(2'd2, c[0] ? 8'h20 : 8'h00);
         wr(2'd1, 8'h55);
         chk("R6 key gives output", pd_oe, 1'b1);
         rd(2'd1, r); chk("R7 status not select", r, 8'h07);
         wr(2'd1, 8'hAA);
         chk("R6 complement gives input", pd_oe, 1'b0);
         wr(2'd1, 8'h54);
         chk("R6 near key gives input", pd_oe, 1'b0);
         wr(2'd1, 8'h00);
         chk("R6 zero gives input", pd_oe, 1'b0);
      end
      wr(2'd1, 8'h55);
      wr(2'd0, 8'hC3);
      rd(2'd0, r); chk("R8 key output write", r, 8'hC3);
      chk("R8 key output pins", pd_out, 8'hC3);

      // R10: spare slot
      wr(2'd2, 8'h1F);
      wr(2'd3, 8'hFF);
      rd(2'd3, r); chk("R10 spare reads zero", r, 8'h00);
      rd(2'd0, r); chk("R10 data unchanged", r, 8'hC3);
      rd(2'd2, r); chk("R10 control unchanged", r, 8'hFF);
      chk("R10 still output", pd_oe, 1'b1);
      wr(2'd3, 8'h00);
      rd(2'd2, r); chk("R10 control unchanged again", r, 8'hFF);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule